// File: doc/BRIEF.md
# Shared-Buffer Packet Admission Controller

This block sits in the hub of a small shared-memory switch. Several ingress ports stream packets one byte per strobe, with a byte index that counts from zero up to the last byte of a fixed-size slot. At the first byte of each packet the controller picks where the packet goes. It may store the packet in a slot taken from the free-slot list. It may store it in a slot that the same port kept from an earlier packet it discarded. It may discard the packet in the hub. Or it may leave the packet to the ingress port to discard. When the last byte of a stored packet arrives, the slot index is handed to the packet's egress queue, unless that queue is full.

Congestion splits the drop duty between two parties.

- **Shared memory exhausted:** the ports lose their ready indication and discard their own packets.
- **Egress queue full:** the hub discards the packet. It keeps the slot for that port's next packet instead of returning it to the free list.
- **Both conditions present:** a per-destination record of which resource filled first decides who discards.

The packet memory, the free-slot list storage and the egress queues lie outside the block. They appear only as a slot head with a pop strobe, an empty flag, full flags and enqueue strobes.

Top module: `pkt_admit_ctrl`

## Requirements
- R1: After reset, with the free list not empty, every port is ready, no port is dropping, no enqueue is issued and no slot is popped.
- R2: A port's ready output is high exactly when the free list is not empty or that port holds a slot kept for reuse.
- R3: A packet start (strobe with byte index 0) on a port with no kept slot, no running cooldown and a non-empty free list pops the free-list head in that same cycle. One cycle after the packet's last byte (index all ones), that slot index is enqueued towards the destination that was presented with the first byte.
- R4: When several ports start packets in the same cycle and all need a new slot, only the lowest-numbered port pops a slot. Each of the others enters the dropping state and enqueues nothing.
- R5: A packet start that finds the free list empty, with no kept slot and no hub-drop condition, puts the port into the dropping state from the next cycle. That packet is never enqueued.
- R6: A dropping port leaves the dropping state only after a last-byte strobe seen while its ready output is high. Otherwise it stays dropping through whole further packets, and packet starts seen while dropping pop nothing.
- R7: If the destination queue is full when a stored packet's last byte arrives, nothing is enqueued and the port keeps the slot. The port's next packet is written into that slot without a pop, is enqueued with that same slot index, and the kept mark is cleared.
- R8: After a port pops a slot, it pops no further slot for 500 cycles. A packet start during that window with no kept slot is dropped by the port.
- R9: The tie case has three conditions: the free list is empty, the destination queue is full, and the port holds no kept slot. If the destination queue was already full in a cycle when the free list was non-empty, the hub discards the packet: no pop, no enqueue, the port does not enter the dropping state and keeps no slot. If the memory ran out no later than the queue filled, the port drops.
- R10: Ready only gates the start of a packet. A packet already being stored is enqueued normally even if the free list becomes empty mid-packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | NPORTS | Byte strobe per ingress port |
| in_idx | input | NPORTS*IDX_W | Byte index within the packet, per port |
| in_dest | input | NPORTS*DEST_W | Destination queue, sampled with byte index 0 |
| free_empty | input | 1 | Free-slot list is empty |
| free_slot | input | SLOT_W | Slot index at the head of the free list |
| free_pop | output | 1 | Take the free-list head this cycle |
| q_full | input | NDEST | Destination queue full flags |
| port_rdy | output | NPORTS | Port may start a new packet |
| port_dropping | output | NPORTS | Port is discarding the bytes it receives |
| enq_vld | output | NPORTS | Enqueue strobe, one per port |
| enq_dest | output | NPORTS*DEST_W | Destination queue of the enqueue, per port |
| enq_slot | output | NPORTS*SLOT_W | Slot index to enqueue, per port |

## Verification
Two kinds of coincidence are provoked.

- **Simultaneous starts:** several ports start packets in the same cycle. Slot allocation for the lowest-numbered port then coincides with the ingress drop decision for the others. It is judged by counting exactly one pop, one enqueue carrying the popped index, and the dropping flag on every other starter.
- **Exhaustion against queue full:** memory exhaustion is raised either after a destination queue went full, or in the same cycle. The first order must give a silent hub discard, with no pop, no enqueue and no dropping flag. The second must give a port drop.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int unsigned PA_NPORTS = 4;
    localparam int unsigned PA_NDEST  = 4;
    localparam int unsigned PA_SLOT_W = 10;
    localparam int unsigned PA_IDX_W  = 6;
    localparam int unsigned PA_COOL   = 500;

    typedef enum logic [1:0] {
        PM_IDLE    = 2'd0,
        PM_STORE   = 2'd1,
        PM_HUBDROP = 2'd2,
        PM_DROP    = 2'd3
    } port_mode_e;
endpackage

// File: rtl/pa_lowest_arb.sv
module pa_lowest_arb #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N-1:0] gnt_d;

    always_comb begin
        gnt_d = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_d    = '0;
                gnt_d[i] = 1'b1;
            end
        end
    end

    assign gnt = gnt_d;
endmodule

// File: rtl/pa_full_order.sv
module pa_full_order #(
    parameter int unsigned NDEST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NDEST-1:0] q_full,
    input  logic             mem_empty,
    output logic [NDEST-1:0] dest_first
);
    logic [NDEST-1:0] first_d, first_q;

    // A queue counts as "first" if it was full during any cycle with free slots left.
    always_comb begin
        first_d = q_full & (first_q | {NDEST{~mem_empty}});
    end

    always_ff @(posedge clk) begin
        if (rst) first_q <= '0;
        else     first_q <= first_d;
    end

    assign dest_first = first_q;
endmodule

// File: rtl/pa_port_ctrl.sv
module pa_port_ctrl
    import pa_pkg::*;
#(
    parameter int unsigned NDEST  = 4,
    parameter int unsigned SLOT_W = 10,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned COOL   = 500,
    parameter int unsigned DEST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bvld,
    input  logic [IDX_W-1:0]  bidx,
    input  logic [DEST_W-1:0] bdest,
    input  logic              free_empty,
    input  logic [SLOT_W-1:0] free_slot,
    input  logic              grant,
    input  logic [NDEST-1:0]  q_full,
    input  logic [NDEST-1:0]  dest_first,
    output logic              req,
    output logic              rdy,
    output logic              dropping,
    output logic              enq_vld,
    output logic [DEST_W-1:0] enq_dest,
    output logic [SLOT_W-1:0] enq_slot
);
    localparam int unsigned COOL_W = $clog2(COOL + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    typedef struct packed {
        port_mode_e        mode;
        logic              reuse;
        logic [SLOT_W-1:0] slot;
        logic [DEST_W-1:0] dest;
        logic [COOL_W-1:0] cool;
        logic              enq;
    } port_state_t;

    port_state_t st_d, st_q;
    logic start, last;

    assign start = bvld && (bidx == '0);
    assign last  = bvld && (bidx == LAST_IDX);
    assign rdy   = !free_empty || st_q.reuse;
    assign req   = start && (st_q.mode == PM_IDLE) && !st_q.reuse &&
                   (st_q.cool == '0) && !free_empty;

    always_comb begin
        st_d     = st_q;
        st_d.enq = 1'b0;
        if (st_q.cool != '0) st_d.cool = st_q.cool - 1'b1;
        unique case (st_q.mode)
            PM_IDLE: begin
                if (start) begin
                    st_d.dest = bdest;
                    if (st_q.reuse) begin
                        st_d.mode  = PM_STORE;
                        st_d.reuse = 1'b0;
                    end else if (grant) begin
                        st_d.mode = PM_STORE;
                        st_d.slot = free_slot;
                        st_d.cool = COOL_W'(COOL);
                    end else if (free_empty && q_full[bdest] && dest_first[bdest]) begin
                        st_d.mode = PM_HUBDROP;
                    end else begin
                        st_d.mode = PM_DROP;
                    end
                end
            end
            PM_STORE: begin
                if (last) begin
                    st_d.mode = PM_IDLE;
                    if (q_full[st_q.dest]) st_d.reuse = 1'b1;
                    else                   st_d.enq   = 1'b1;
                end
            end
            PM_HUBDROP: begin
                if (last) st_d.mode = PM_IDLE;
            end
            PM_DROP: begin
                if (last && rdy) st_d.mode = PM_IDLE;
            end
            default: st_d.mode = PM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dropping = (st_q.mode == PM_DROP);
    assign enq_vld  = st_q.enq;
    assign enq_dest = st_q.dest;
    assign enq_slot = st_q.slot;
endmodule

// File: rtl/pkt_admit_ctrl.sv
module pkt_admit_ctrl
    import pa_pkg::*;
#(
    parameter int unsigned NPORTS = PA_NPORTS,
    parameter int unsigned NDEST  = PA_NDEST,
    parameter int unsigned SLOT_W = PA_SLOT_W,
    parameter int unsigned IDX_W  = PA_IDX_W,
    parameter int unsigned COOL   = PA_COOL
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORTS-1:0]        in_vld,
    input  logic [NPORTS*IDX_W-1:0]  in_idx,
    input  logic [NPORTS*((NDEST > 1) ? $clog2(NDEST) : 1)-1:0] in_dest,
    input  logic                     free_empty,
    input  logic [SLOT_W-1:0]        free_slot,
    output logic                     free_pop,
    input  logic [NDEST-1:0]         q_full,
    output logic [NPORTS-1:0]        port_rdy,
    output logic [NPORTS-1:0]        port_dropping,
    output logic [NPORTS-1:0]        enq_vld,
    output logic [NPORTS*((NDEST > 1) ? $clog2(NDEST) : 1)-1:0] enq_dest,
    output logic [NPORTS*SLOT_W-1:0] enq_slot
);
    localparam int unsigned DEST_W = (NDEST > 1) ? $clog2(NDEST) : 1;

    logic [NPORTS-1:0] req, gnt;
    logic [NDEST-1:0]  dest_first;

    pa_full_order #(.NDEST(NDEST)) u_order (
        .clk       (clk),
        .rst       (rst),
        .q_full    (q_full),
        .mem_empty (free_empty),
        .dest_first(dest_first)
    );

    pa_lowest_arb #(.N(NPORTS)) u_arb (
        .req(req),
        .gnt(gnt)
    );

    assign free_pop = |gnt;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        pa_port_ctrl #(
            .NDEST (NDEST),
            .SLOT_W(SLOT_W),
            .IDX_W (IDX_W),
            .COOL  (COOL),
            .DEST_W(DEST_W)
        ) u_port (
            .clk       (clk),
            .rst       (rst),
            .bvld      (in_vld[p]),
            .bidx      (in_idx[p*IDX_W +: IDX_W]),
            .bdest     (in_dest[p*DEST_W +: DEST_W]),
            .free_empty(free_empty),
            .free_slot (free_slot),
            .grant     (gnt[p]),
            .q_full    (q_full),
            .dest_first(dest_first),
            .req       (req[p]),
            .rdy       (port_rdy[p]),
            .dropping  (port_dropping[p]),
            .enq_vld   (enq_vld[p]),
            .enq_dest  (enq_dest[p*DEST_W +: DEST_W]),
            .enq_slot  (enq_slot[p*SLOT_W +: SLOT_W])
        );
    end
endmodule

// File: rtl/pkt_admit_chk.sv
module pkt_admit_chk #(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned NDEST  = 4,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned DEST_W = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NPORTS-1:0]        in_vld,
    input logic [NPORTS*IDX_W-1:0]  in_idx,
    input logic                     free_empty,
    input logic                     free_pop,
    input logic [NDEST-1:0]         q_full,
    input logic [NPORTS-1:0]        port_rdy,
    input logic [NPORTS-1:0]        port_dropping,
    input logic [NPORTS-1:0]        enq_vld,
    input logic [NPORTS*DEST_W-1:0] enq_dest
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    logic [NDEST-1:0] full_prev_q;
    always_ff @(posedge clk) begin
        if (rst) full_prev_q <= '0;
        else     full_prev_q <= q_full;
    end

    // R2
    all_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !free_empty |-> (&port_rdy));

    // R3
    pop_needs_slot_chk: assert property (@(posedge clk) disable iff (rst)
        free_pop |-> !free_empty);

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        // R5
        drop_on_start_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(port_dropping[p]) |->
                ($past(in_vld[p]) && ($past(in_idx[p*IDX_W +: IDX_W]) == '0)));

        // R6
        drop_exit_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(port_dropping[p]) |->
                ($past(in_vld[p]) && ($past(in_idx[p*IDX_W +: IDX_W]) == LAST_IDX) &&
                 $past(port_rdy[p])));

        // R3
        enq_after_last_chk: assert property (@(posedge clk) disable iff (rst)
            enq_vld[p] |->
                ($past(in_vld[p]) && ($past(in_idx[p*IDX_W +: IDX_W]) == LAST_IDX)));

        // R7
        enq_not_full_chk: assert property (@(posedge clk) disable iff (rst)
            enq_vld[p] |-> !full_prev_q[enq_dest[p*DEST_W +: DEST_W]]);
    end
endmodule

bind pkt_admit_ctrl pkt_admit_chk #(
    .NPORTS(NPORTS),
    .NDEST (NDEST),
    .IDX_W (IDX_W),
    .DEST_W(DEST_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_vld       (in_vld),
    .in_idx       (in_idx),
    .free_empty   (free_empty),
    .free_pop     (free_pop),
    .q_full       (q_full),
    .port_rdy     (port_rdy),
    .port_dropping(port_dropping),
    .enq_vld      (enq_vld),
    .enq_dest     (enq_dest)
);

// File: tb/tb_pkt_admit_ctrl.sv
module tb_pkt_admit_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  in_vld;
    logic [23:0] in_idx;
    logic [7:0]  in_dest;
    logic        free_empty;
    logic [9:0]  free_slot;
    logic        free_pop;
    logic [3:0]  q_full;
    logic [3:0]  port_rdy;
    logic [3:0]  port_dropping;
    logic [3:0]  enq_vld;
    logic [7:0]  enq_dest;
    logic [39:0] enq_slot;

    int checks = 0;
    int errors = 0;
    int pops;
    logic [3:0] enq_seen, drop_seen;
    logic [9:0] slot_rec [4];
    logic [1:0] dest_rec [4];

    always #10 clk = ~clk;

    pkt_admit_ctrl dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_idx(in_idx), .in_dest(in_dest),
        .free_empty(free_empty), .free_slot(free_slot), .free_pop(free_pop),
        .q_full(q_full), .port_rdy(port_rdy), .port_dropping(port_dropping),
        .enq_vld(enq_vld), .enq_dest(enq_dest), .enq_slot(enq_slot)
    );

    // fields: mask, dests, q_full, free_empty, pops, enq mask, drop mask
    localparam int NV = 6;
    localparam logic [26:0] VEC [NV] = '{
        {4'b0001, 8'h02, 4'b0000, 1'b0, 2'd1, 4'b0001, 4'b0000},
        {4'b0110, 8'h34, 4'b0000, 1'b0, 2'd1, 4'b0010, 4'b0100},
        {4'b1111, 8'h00, 4'b0000, 1'b0, 2'd1, 4'b0001, 4'b1110},
        {4'b0001, 8'h00, 4'b0000, 1'b1, 2'd0, 4'b0000, 4'b0001},
        {4'b0001, 8'h02, 4'b0100, 1'b0, 2'd1, 4'b0000, 4'b0000},
        {4'b1000, 8'hC0, 4'b0000, 1'b0, 2'd1, 4'b1000, 4'b0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; in_vld = '0; in_idx = '0; in_dest = '0;
        free_empty = 1'b0; free_slot = 10'd100; q_full = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic record();
        drop_seen = drop_seen | port_dropping;
        for (int p = 0; p < 4; p++) begin
            if (enq_vld[p]) begin
                enq_seen[p] = 1'b1;
                slot_rec[p] = enq_slot[p*10 +: 10];
                dest_rec[p] = enq_dest[p*2 +: 2];
            end
        end
    endtask

    task automatic run_pkts(input logic [3:0] mask, input logic [7:0] dests, input int empty_at);
        logic popped;
        pops = 0; enq_seen = '0; drop_seen = '0;
        for (int i = 0; i < 64; i++) begin
            in_vld = mask; in_dest = dests;
            for (int p = 0; p < 4; p++) in_idx[p*6 +: 6] = 6'(i);
            if (empty_at >= 0 && i >= empty_at) free_empty = 1'b1;
            #1;
            popped = free_pop;
            if (popped) pops++;
            @(negedge clk);
            if (popped) free_slot = free_slot + 10'd1;
            record();
        end
        in_vld = '0;
        @(negedge clk);
        record();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // table walk: R3 R4 R5 R7 scenarios from reset
        for (int v = 0; v < NV; v++) begin
            do_reset();
            q_full = VEC[v][14:11];
            free_empty = VEC[v][10];
            run_pkts(VEC[v][26:23], VEC[v][22:15], -1);
            check($sformatf("R3 table %0d pops", v), pops, 32'(VEC[v][9:8]));
            check($sformatf("R4 table %0d enqueue mask", v), 32'(enq_seen), 32'(VEC[v][7:4]));
            check($sformatf("R5 table %0d drop mask", v), 32'(drop_seen), 32'(VEC[v][3:0]));
            for (int p = 0; p < 4; p++) begin
                if (VEC[v][4+p]) begin
                    check($sformatf("R3 table %0d slot", v), 32'(slot_rec[p]), 32'd100);
                    check($sformatf("R3 table %0d dest", v), 32'(dest_rec[p]),
                          32'(VEC[v][15+2*p +: 2]));
                end
            end
        end

        // R1 reset state, R2 ready vs memory
        do_reset();
        #1;
        check("R1 ready after reset", 32'(port_rdy), 32'hF);
        check("R1 dropping after reset", 32'(port_dropping), 32'h0);
        check("R1 enqueue after reset", 32'(enq_vld), 32'h0);
        check("R1 pop after reset", 32'(free_pop), 32'h0);
        free_empty = 1'b1;
        #1;
        check("R2 ready with memory empty", 32'(port_rdy), 32'h0);

        // R7 kept slot reused for the next packet
        do_reset();
        q_full = 4'b0100;
        run_pkts(4'b0001, 8'h02, -1);
        check("R7 no enqueue to full queue", 32'(enq_seen), 32'h0);
        free_empty = 1'b1; q_full = '0;
        #1;
        check("R2 ready from kept slot", 32'(port_rdy), 32'h1);
        run_pkts(4'b0001, 8'h00, -1);
        check("R7 reuse pops nothing", pops, 0);
        check("R7 reuse enqueues", 32'(enq_seen), 32'h1);
        check("R7 reuse slot index", 32'(slot_rec[0]), 32'd100);
        check("R7 reuse dest", 32'(dest_rec[0]), 32'd0);
        #1;
        check("R7 kept mark cleared", 32'(port_rdy), 32'h0);

        // R6 dropping persists without ready
        do_reset();
        free_empty = 1'b1;
        run_pkts(4'b0001, 8'h00, -1);
        check("R6 dropping held at boundary", 32'(port_dropping[0]), 32'h1);
        run_pkts(4'b0001, 8'h00, -1);
        check("R6 still dropping", 32'(port_dropping[0]), 32'h1);
        check("R6 nothing enqueued", 32'(enq_seen), 32'h0);
        free_empty = 1'b0;
        run_pkts(4'b0001, 8'h00, -1);
        check("R6 start while dropping pops nothing", pops, 0);
        check("R6 dropping left at boundary", 32'(port_dropping[0]), 32'h0);
        run_pkts(4'b0001, 8'h00, -1);
        check("R6 accepted after exit", pops, 1);
        check("R6 enqueued after exit", 32'(enq_seen), 32'h1);

        // R8 cooldown
        do_reset();
        run_pkts(4'b0001, 8'h00, -1);
        check("R8 first pop", pops, 1);
        run_pkts(4'b0001, 8'h00, -1);
        check("R8 no pop in cooldown", pops, 0);
        check("R8 dropped in cooldown", 32'(drop_seen[0]), 32'h1);
        check("R8 no enqueue in cooldown", 32'(enq_seen), 32'h0);
        repeat (450) @(negedge clk);
        run_pkts(4'b0001, 8'h00, -1);
        check("R8 pop after cooldown", pops, 1);
        check("R8 slot after cooldown", 32'(slot_rec[0]), 32'd101);

        // R9 queue filled first: hub discards
        do_reset();
        q_full = 4'b0010;
        repeat (2) @(negedge clk);
        free_empty = 1'b1;
        @(negedge clk);
        run_pkts(4'b0001, 8'h01, -1);
        check("R9 hub drop pops nothing", pops, 0);
        check("R9 hub drop not port drop", 32'(drop_seen), 32'h0);
        check("R9 hub drop no enqueue", 32'(enq_seen), 32'h0);
        #1;
        check("R9 hub drop keeps no slot", 32'(port_rdy[0]), 32'h0);
        // R9 both filled together: port discards
        do_reset();
        free_empty = 1'b1; q_full = 4'b0010;
        repeat (2) @(negedge clk);
        run_pkts(4'b0001, 8'h01, -1);
        check("R9 port drop when memory not later", 32'(drop_seen), 32'h1);

        // R10 memory empties mid-packet
        do_reset();
        run_pkts(4'b0001, 8'h00, 10);
        check("R10 pop", pops, 1);
        check("R10 enqueue completes", 32'(enq_seen), 32'h1);
        check("R10 no drop", 32'(drop_seen), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule